// File: doc/BRIEF.md
# PCM Link Serial-to-Parallel Receiver

This block is the receive half of one T1/E1 framer port. The framer supplies a serial bit stream, a bit clock and a frame sync pulse. The block brings all three into the system clock domain and finds the active edge of the bit clock. It then counts bit positions inside the frame. From the timeslots that carry payload it assembles bytes, and hands each one downstream as a byte, a channel ordinal and a one-cycle valid strobe.

The link mode selects one of four mappings. E1 uses 32 slots. T1 can use the low 24 slots of a 32-slot 2.048 Mbit/s frame, or three slots of every four in that frame. T1 can also run on native 193-bit framing. Another option keeps the last T1 channel back for signalling. The clock edge and the sync level are each selectable. The block checks every sync pulse against the expected frame length and sets a sticky alarm when a pulse comes early or late.

Top module: `s2p_rx_port`

## Requirements
- R1: After reset, byte_valid is 0, byte_data and byte_chan are 0, and sync_err is 0.
- R2: With link_mode 0 (E1, 256-bit frame) slots 0 and 16 yield no byte. Slot s in 1..15 yields channel s-1, and slot s in 17..31 yields channel s-2. That gives 30 bytes per frame. Each byte takes its first received bit as bit 7.
- R3: With link_mode 1 (T1 on the low 24 slots of a 256-bit frame) slots 0..23 yield channels 0..23 and the later slots yield nothing.
- R4: With link_mode 2 (T1 on three of four slots of a 256-bit frame) a slot s with s mod 4 equal to 3 yields nothing. Any other slot yields channel s - floor(s/4), so slot 30 is channel 23.
- R5: With link_mode 3 (native T1, 193-bit frame) bits 0..191 form slots 0..23, which give channels 0..23. Bit 192 is discarded.
- R6: With reserve_last set, channel 23 is not delivered in modes 1, 2 and 3. In mode 0 reserve_last has no effect.
- R7: With clk_inv 0, bits are sampled on the rising rx_clk edge. With clk_inv 1 they are sampled on the falling edge.
- R8: With sync_inv 0, rx_sync is active high. With sync_inv 1 it is active low. The bit sampled with sync active is bit 0 of a frame, which is the first bit of slot 0.
- R9: No byte is produced before the first sync pulse after enable or reset.
- R10: A sync on the bit that follows a full frame (256 or 193 bits) leaves sync_err at 0 and realigns the count. A sync anywhere else, once aligned, sets sync_err until reset and does not realign.
- R11: While en is 0 no byte is produced, byte_data and byte_chan read 0, and the alignment is dropped.
- R12: byte_valid is high for exactly one system clock per delivered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| link_mode | input | 2 | 0 E1, 1 T1 low-24, 2 T1 three-of-four, 3 T1 native |
| reserve_last | input | 1 | Keep T1 channel 23 for signalling |
| clk_inv | input | 1 | Sample on the falling rx_clk edge |
| sync_inv | input | 1 | rx_sync is active low |
| rx_clk | input | 1 | Serial bit clock from the framer |
| rx_sync | input | 1 | Frame sync from the framer |
| rx_data | input | 1 | Serial PCM data |
| byte_valid | output | 1 | One-cycle strobe per delivered byte |
| byte_data | output | 8 | Assembled payload byte |
| byte_chan | output | 5 | Payload channel ordinal within the frame |
| sync_err | output | 1 | Sticky unexpected-sync alarm |

## Verification
The bench drives random frames through all four mappings, each with and without the reserved channel. A design that mis-skips slot 16 shifts every later E1 channel by one. A design that gets the three-of-four formula wrong delivers slot 3 or loses slot 30. A design that keeps the 193rd bit slips every following native frame by one bit. Bits sent before the first sync, and a whole frame sent while disabled, must produce nothing; a design that counts without alignment leaks bytes there. The polarity phase swaps the clock edge and the sync level together, and an edge error misreads every bit. A final early sync must raise the alarm, while correctly spaced syncs must never raise it.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  localparam int unsigned SLOT_BITS      = 8;
  localparam int unsigned WIDE_FRAME     = 256;
  localparam int unsigned NATIVE_FRAME   = 193;
  localparam int unsigned POS_W          = $clog2(WIDE_FRAME);
  localparam int unsigned SLOT_W         = POS_W - $clog2(SLOT_BITS);
  localparam int unsigned CHAN_W         = 5;
  localparam int unsigned T1_LAST_CHAN   = 23;
  localparam int unsigned E1_SKIP_A      = 0;
  localparam int unsigned E1_SKIP_B      = 16;

  typedef enum logic [1:0] {
    LM_E1        = 2'd0,
    LM_T1_LOW24  = 2'd1,
    LM_T1_SPREAD = 2'd2,
    LM_T1_NATIVE = 2'd3
  } link_mode_e;

  typedef struct packed {
    logic              hit;
    logic [CHAN_W-1:0] chan;
  } slot_map_t;

  function automatic logic [POS_W-1:0] last_pos(link_mode_e m);
    int unsigned len;
    len = (m == LM_T1_NATIVE) ? NATIVE_FRAME : WIDE_FRAME;
    return POS_W'(len - 1);
  endfunction

  function automatic slot_map_t map_slot(link_mode_e m, logic [SLOT_W-1:0] s, logic rsv);
    slot_map_t r;
    r.hit  = 1'b0;
    r.chan = '0;
    unique case (m)
      LM_E1: begin
        r.hit  = (s != SLOT_W'(E1_SKIP_A)) && (s != SLOT_W'(E1_SKIP_B));
        r.chan = (s < SLOT_W'(E1_SKIP_B)) ? CHAN_W'(s - 1) : CHAN_W'(s - 2);
      end
      LM_T1_SPREAD: begin
        r.hit  = (s[1:0] != 2'b11);
        r.chan = CHAN_W'(s - SLOT_W'(s[SLOT_W-1:2]));
      end
      default: begin
        r.hit  = (s < SLOT_W'(T1_LAST_CHAN + 1));
        r.chan = CHAN_W'(s);
      end
    endcase
    if (rsv && (m != LM_E1) && (r.chan == CHAN_W'(T1_LAST_CHAN)))
      r.hit = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk,
  input  logic rx_data,
  input  logic rx_sync,
  input  logic clk_inv,
  input  logic sync_inv,
  output logic bit_stb,
  output logic bit_val,
  output logic sync_lvl
);
  logic [STAGES-1:0] c_sr, d_sr, s_sr;
  logic              lvl, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_sr  <= '0;
      d_sr  <= '0;
      s_sr  <= '0;
      lvl_q <= 1'b0;
    end else begin
      c_sr  <= {c_sr[STAGES-2:0], rx_clk};
      d_sr  <= {d_sr[STAGES-2:0], rx_data};
      s_sr  <= {s_sr[STAGES-2:0], rx_sync};
      lvl_q <= lvl;
    end
  end

  assign lvl      = c_sr[STAGES-1] ^ clk_inv;
  assign bit_stb  = lvl & ~lvl_q;
  assign bit_val  = d_sr[STAGES-1];
  assign sync_lvl = s_sr[STAGES-1] ^ sync_inv;

  p_strobe_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/rx_frame_track.sv
module rx_frame_track
  import s2p_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  link_mode_e       mode,
  input  logic             bit_stb,
  input  logic             sync_lvl,
  output logic             bit_evt,
  output logic [POS_W-1:0] bit_pos,
  output logic             sync_err
);
  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] last;
  logic             locked, at_end, good_sync, bad_sync_evt, lock_now;

  assign last         = last_pos(mode);
  assign at_end       = (cnt == last);
  assign good_sync    = sync_lvl && (!locked || at_end);
  assign bad_sync_evt = en && bit_stb && sync_lvl && locked && !at_end;
  assign lock_now     = locked | good_sync;
  assign bit_pos      = good_sync ? '0 : (at_end ? '0 : cnt + 1'b1);
  assign bit_evt      = en && bit_stb && lock_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (bit_stb) begin
      cnt    <= bit_pos;
      locked <= lock_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sync_err <= 1'b0;
    else if (bad_sync_evt) sync_err <= 1'b1;
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
  p_pos_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |-> bit_pos <= last);
  p_evt_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> locked);
  p_off_unlocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);
endmodule

// File: rtl/rx_byte_pack.sv
module rx_byte_pack
  import s2p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  link_mode_e        mode,
  input  logic              reserve_last,
  input  logic              bit_evt,
  input  logic              bit_val,
  input  logic [POS_W-1:0]  bit_pos,
  output logic              out_valid,
  output logic [SLOT_BITS-1:0] out_byte,
  output logic [CHAN_W-1:0] out_chan
);
  localparam int unsigned IDX_W = $clog2(SLOT_BITS);

  logic [SLOT_BITS-2:0] sh;
  logic [SLOT_BITS-1:0] full_byte;
  slot_map_t            map;
  logic                 byte_end, take;

  assign full_byte = {sh, bit_val};
  assign map       = map_slot(mode, bit_pos[POS_W-1:IDX_W], reserve_last);
  assign byte_end  = (bit_pos[IDX_W-1:0] == IDX_W'(SLOT_BITS - 1));
  assign take      = bit_evt && byte_end && map.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh <= '0;
    else if (bit_evt) sh <= full_byte[SLOT_BITS-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_chan  <= '0;
    end else if (!en) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_byte <= full_byte;
        out_chan <= map.chan;
      end
    end
  end

  p_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_valid && out_byte == '0 && out_chan == '0));
  p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_chan < CHAN_W'(30));
  p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && reserve_last && mode != LM_E1) |-> map.chan != CHAN_W'(T1_LAST_CHAN));
endmodule

// File: rtl/s2p_rx_port.sv
module s2p_rx_port
  import s2p_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] link_mode,
  input  logic       reserve_last,
  input  logic       clk_inv,
  input  logic       sync_inv,
  input  logic       rx_clk,
  input  logic       rx_sync,
  input  logic       rx_data,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [4:0] byte_chan,
  output logic       sync_err
);
  link_mode_e       mode;
  logic             bit_stb, bit_val, sync_lvl, bit_evt;
  logic [POS_W-1:0] bit_pos;

  assign mode = link_mode_e'(link_mode);

  rx_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data),
    .rx_sync(rx_sync), .clk_inv(clk_inv), .sync_inv(sync_inv),
    .bit_stb(bit_stb), .bit_val(bit_val), .sync_lvl(sync_lvl)
  );

  rx_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .bit_stb(bit_stb),
    .sync_lvl(sync_lvl), .bit_evt(bit_evt), .bit_pos(bit_pos),
    .sync_err(sync_err)
  );

  rx_byte_pack u_pack (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .reserve_last(reserve_last), .bit_evt(bit_evt), .bit_val(bit_val),
    .bit_pos(bit_pos), .out_valid(byte_valid), .out_byte(byte_data),
    .out_chan(byte_chan)
  );
endmodule

// File: tb/tb_s2p_rx_port.sv
`timescale 1ns/1ps
module tb_s2p_rx_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       en = 0;
  logic [1:0] link_mode = 0;
  logic       reserve_last = 0, clk_inv = 0, sync_inv = 0;
  logic       rx_clk = 0, rx_sync = 0, rx_data = 0;
  logic       byte_valid, sync_err;
  logic [7:0] byte_data;
  logic [4:0] byte_chan;

  int vectors = 0, fails = 0;
  bit mon_on = 0;
  logic [12:0] expq[$];

  always #2 clk = ~clk;

  s2p_rx_port dut (.*);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_pay(int m, int s);
    if (m == 0) return !(s == 0 || s == 16);
    if (m == 2) return (s % 4) != 3;
    return s < 24;
  endfunction

  function automatic int exp_chan(int m, int s, bit rsv);
    int n = 0;
    if (!is_pay(m, s)) return -1;
    for (int k = 0; k < s; k++) if (is_pay(m, k)) n++;
    if (rsv && m != 0 && n == 23) return -1;
    return n;
  endfunction

  task automatic drive_bit(input bit d, input bit s);
    @(negedge clk);
    rx_data = d;
    rx_sync = s ^ sync_inv;
    repeat (4) @(negedge clk);
    rx_clk = ~clk_inv;
    repeat (4) @(negedge clk);
    rx_clk = clk_inv;
  endtask

  task automatic send_frame(input bit expect_out);
    int nb;
    logic [7:0] slot_b [32];
    nb = (link_mode == 3) ? 193 : 256;
    for (int s = 0; s < 32; s++) begin
      slot_b[s] = 8'($urandom);
      if (expect_out && (s * 8 < nb - 7) && exp_chan(int'(link_mode), s, reserve_last) >= 0)
        expq.push_back({5'(exp_chan(int'(link_mode), s, reserve_last)), slot_b[s]});
    end
    for (int b = 0; b < nb; b++)
      drive_bit((b < 256) ? slot_b[b / 8][7 - (b % 8)] : 1'b0, b == 0);
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n && byte_valid) begin
      if (expq.size() == 0) begin
        check(0, "R9/R11", "unexpected byte on chan", int'(byte_chan), -1);
      end else begin
        logic [12:0] e;
        e = expq.pop_front();
        check(byte_chan == e[12:8], "R2-mapping chan", "channel", int'(byte_chan), int'(e[12:8]));
        check(byte_data == e[7:0], "R2/R3/R4/R5 data", "byte", int'(byte_data), int'(e[7:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(byte_valid == 0, "R1", "byte_valid", byte_valid, 0);
    check(byte_data == 0 && byte_chan == 0, "R1", "byte_data", byte_data, 0);
    check(sync_err == 0, "R1", "sync_err", sync_err, 0);
    rst_n = 1;
    mon_on = 1;
    en = 1;
    // R9: bits before any sync give nothing
    for (int i = 0; i < 40; i++) drive_bit(1'($urandom), 0);
    // R2, R6 (E1 ignores reserve)
    link_mode = 0; reserve_last = 0; send_frame(1);
    reserve_last = 1; send_frame(1);
    // R3, R6
    link_mode = 1; reserve_last = 0; send_frame(1);
    reserve_last = 1; send_frame(1);
    // R4, R6
    link_mode = 2; reserve_last = 0; send_frame(1);
    reserve_last = 1; send_frame(1);
    repeat (20) @(negedge clk);
    check(sync_err == 0, "R10", "sync_err after aligned frames", sync_err, 0);
    // R11: disabled port
    en = 0;
    send_frame(0);
    check(byte_data == 0 && byte_chan == 0, "R11", "outputs while off", byte_data, 0);
    // R5 native framing
    link_mode = 3; reserve_last = 0; en = 1;
    send_frame(1); send_frame(1);
    reserve_last = 1; send_frame(1);
    repeat (20) @(negedge clk);
    check(sync_err == 0, "R10", "sync_err after native frames", sync_err, 0);
    // R7, R8 inverted clock edge and sync level
    en = 0; clk_inv = 1; sync_inv = 1; rx_clk = 1; rx_sync = 1;
    repeat (10) @(negedge clk);
    link_mode = 0; reserve_last = 0; en = 1;
    send_frame(1); send_frame(1);
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R12", "pending expected bytes", expq.size(), 0);
    check(sync_err == 0, "R10", "sync_err before early sync", sync_err, 0);
    // R10 early sync raises sticky alarm
    mon_on = 0;
    for (int b = 0; b < 100; b++) drive_bit(1'($urandom), 0);
    drive_bit(0, 1);
    for (int b = 0; b < 20; b++) drive_bit(0, 0);
    check(sync_err == 1, "R10", "sync_err after early sync", sync_err, 1);
    send_frame(0);
    check(sync_err == 1, "R10", "sync_err stays set", sync_err, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule